// File: doc/BRIEF.md
# Legacy Load/Store Alignment Unit

This block sits between the load/store stage of a 32-bit processor and a word-addressed data memory. It converts each byte-addressed request into a word-aligned memory access with byte enables. It places store data in the correct byte lanes. On the return path it extracts, extends or rotates the data read back. It also applies the older unaligned-access rules.

With strict checking off, an unaligned single-word load returns the aligned word rotated right by the byte offset. An unaligned single-word store writes the aligned word and ignores the low address bits. Accesses whose result would be undefined raise an unpredictable flag. With strict checking on, every access that is not aligned to its own size raises an alignment fault, and no memory access is made for it.

A request is presented for one cycle together with its address and store data. The memory is synchronous: it accepts the word address and enables in the request cycle and returns read data in the next cycle. In that next cycle the unit raises its response strobe. The response carries the shaped load data and the fault and unpredictable indications for the request. Requests may be issued back to back.

Top module: `lsa_unit`

## Requirements
- R1: `resp_valid` is high exactly one cycle after each cycle with `req_valid` high. `resp_fault` and `resp_unpred` describe that request in the same cycle. The access-kind codes on `req_kind` are: 0 byte, 1 halfword, 2 single word, 3 paired word, 4 register-list (multiple) transfer, 5 swap.
- R2: Whenever `mem_en` is high, `mem_addr` equals `req_addr` with bits [1:0] cleared, for every access kind.
- R3: With `chk_en` low and `req_compact` low, a word or swap load at byte offset k = `req_addr[1:0]` returns the aligned word rotated right by 8·k bits, with neither flag set.
- R4: A word or swap store that is not faulted drives `mem_be` = 4'b1111 and `mem_wdata` = `req_wdata` unrotated, whatever the offset.
- R5: Multiple and paired transfers return the read word unmodified. A store of either kind drives `mem_be` = 4'b1111. A multiple transfer never raises a fault or the unpredictable flag, at any offset.
- R6: With `chk_en` low, a halfword access with `req_addr[0]` = 1 sets `resp_unpred`. The unpredictable flag is never set while `chk_en` is high.
- R7: With `chk_en` low and `req_compact` high, a word or swap access with nonzero `req_addr[1:0]` sets `resp_unpred`.
- R8: With `chk_en` high, a halfword, word, swap or paired access that is misaligned for its size sets `resp_fault`, and `mem_en` and `mem_we` stay low in the request cycle. A fault is never raised while `chk_en` is low.
- R9: A paired transfer needs `req_addr[2:0]` = 0 when `pair_word_ok` is low, and `req_addr[1:0]` = 0 when it is high. A misaligned pair sets `resp_unpred` when `chk_en` is low and `resp_fault` when `chk_en` is high.
- R10: Byte accesses never fault or flag. The byte lanes are little-endian: offset 0 is data bits [7:0]. A byte store drives `mem_be` = 1 << `req_addr[1:0]` and copies `req_wdata[7:0]` into all four lanes. A byte load returns the selected byte, sign-extended if `req_signed` is 1 and zero-extended otherwise.
- R11: A halfword store drives `mem_be` = 4'b0011 when `req_addr[1]` = 0 and 4'b1100 when it is 1, and copies `req_wdata[15:0]` into both halves. A halfword load returns bits [15:0] or [31:16] of the read word, chosen by `req_addr[1]` and extended as in R10.
- R12: After reset `resp_valid`, `resp_fault` and `resp_unpred` are low. `resp_fault` and `resp_unpred` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Access kind code (see R1) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Sign-extend byte or halfword loads |
| req_compact | input | 1 | Compact instruction-set mode |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| chk_en | input | 1 | Strict alignment checking |
| pair_word_ok | input | 1 | Paired transfers need only 4-byte alignment |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte write enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_en |
| resp_valid | output | 1 | Response strobe |
| resp_data | output | 32 | Shaped load data |
| resp_fault | output | 1 | Alignment fault for the request |
| resp_unpred | output | 1 | Unpredictable access for the request |

## Verification
The assertions assume that `req_kind` only carries the six defined codes. They also assume that `mem_rdata` comes from a synchronous memory that answers one cycle after `mem_en`, and that `chk_en` and `pair_word_ok` are held steady during a request. The stimulus drives only legal kind codes. It changes the two configuration inputs only between groups of requests, and its memory model registers the read word on the clock edge after the access. Within those limits, every kind is swept over offsets 0 to 7 in each combination of checking, instruction mode and pair-alignment choice. Loads check data only when neither flag is raised.

// File: rtl/lsa_pkg.sv
// Shared definitions for the legacy load/store alignment unit.
// Assumes little-endian byte lanes and a data width that is a power-of-two
// multiple of 16 bits.
package lsa_pkg;

    parameter int unsigned LSA_ADDR_W = 32;
    parameter int unsigned LSA_DATA_W = 32;

    typedef enum logic [2:0] {
        ACC_BYTE  = 3'd0,
        ACC_HALF  = 3'd1,
        ACC_WORD  = 3'd2,
        ACC_PAIR  = 3'd3,
        ACC_MULTI = 3'd4,
        ACC_SWAP  = 3'd5
    } acc_kind_e;

endpackage

// File: rtl/lsa_align_check.sv
// Alignment classifier: decides, from the access kind and the low address
// bits, whether a request raises an alignment fault (strict mode) or is
// flagged as unpredictable (legacy mode). Purely combinational.
// Assumes off carries address bits [OFF_W:0], one bit wider than a lane index.
module lsa_align_check
    import lsa_pkg::*;
#(
    parameter int unsigned OFF_W = 2
) (
    input  acc_kind_e        kind,
    input  logic [OFF_W:0]   off,
    input  logic             chk_en,
    input  logic             compact,
    input  logic             pair_word_ok,
    output logic             fault,
    output logic             unpred
);

    logic mis_half;
    logic mis_word;
    logic mis_pair;

    // size-relative misalignment tests
    always_comb begin
        mis_half = off[0];
        mis_word = |off[OFF_W-1:0];
        mis_pair = pair_word_ok ? mis_word : |off;
    end

    // map misalignment to fault or unpredictable according to the mode
    always_comb begin
        fault  = 1'b0;
        unpred = 1'b0;
        case (kind)
            ACC_HALF: begin
                fault  = chk_en & mis_half;
                unpred = ~chk_en & mis_half;
            end
            ACC_WORD, ACC_SWAP: begin
                fault  = chk_en & mis_word;
                unpred = ~chk_en & compact & mis_word;
            end
            ACC_PAIR: begin
                fault  = chk_en & mis_pair;
                unpred = ~chk_en & mis_pair;
            end
            default: begin
                fault  = 1'b0;
                unpred = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lsa_store_path.sv
// Store/address path: clears the low address bits, builds byte enables and
// replicates narrow store data across the lanes. Combinational.
// Assumes at least four byte lanes; enables are forced to zero unless wr_en.
module lsa_store_path
    import lsa_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  acc_kind_e                kind,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     wr_en,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W/8-1:0]      mem_be,
    output logic [DATA_W-1:0]        mem_wdata
);

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);

    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] hbase;
    logic [LANES-1:0] be_raw;

    // word-aligned address and lane offsets
    always_comb begin
        off      = addr[OFF_W-1:0];
        hbase    = {off[OFF_W-1:1], 1'b0};
        mem_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    // byte enables and lane-replicated write data by access kind
    always_comb begin
        case (kind)
            ACC_BYTE: begin
                be_raw    = LANES'(1) << off;
                mem_wdata = {LANES{wdata[7:0]}};
            end
            ACC_HALF: begin
                be_raw    = LANES'(3) << hbase;
                mem_wdata = {(LANES/2){wdata[15:0]}};
            end
            default: begin
                be_raw    = '1;
                mem_wdata = wdata;
            end
        endcase
        mem_be = wr_en ? be_raw : '0;
    end

endmodule

// File: rtl/lsa_load_path.sv
// Load path: forms every byte rotation of the read word, then selects a
// rotated word, a byte or a halfword and extends it. Combinational.
// Assumes off is the byte offset captured with the request.
module lsa_load_path
    import lsa_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  acc_kind_e                       kind,
    input  logic [$clog2(DATA_W/8)-1:0]     off,
    input  logic                            sgn,
    input  logic [DATA_W-1:0]               rdata,
    output logic [DATA_W-1:0]               ldata
);

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);

    logic [DATA_W-1:0] rot [LANES];
    logic [DATA_W-1:0] sel;
    logic [DATA_W-1:0] hsel;

    for (genvar r = 0; r < LANES; r++) begin : g_rot
        if (r == 0) begin : g_zero
            assign rot[r] = rdata;
        end else begin : g_shift
            assign rot[r] = {rdata[8*r-1:0], rdata[DATA_W-1:8*r]};
        end
    end

    // pick the rotation for the byte offset and for the halfword lane
    always_comb begin
        sel  = rot[off];
        hsel = rot[{off[OFF_W-1:1], 1'b0}];
    end

    // shape the returned value by access kind
    always_comb begin
        case (kind)
            ACC_BYTE:
                ldata = sgn ? {{(DATA_W-8){sel[7]}}, sel[7:0]}
                            : {{(DATA_W-8){1'b0}}, sel[7:0]};
            ACC_HALF:
                ldata = sgn ? {{(DATA_W-16){hsel[15]}}, hsel[15:0]}
                            : {{(DATA_W-16){1'b0}}, hsel[15:0]};
            ACC_WORD, ACC_SWAP:
                ldata = sel;
            default:
                ldata = rdata;
        endcase
    end

endmodule

// File: rtl/lsa_unit.sv
// Legacy load/store alignment unit, top level. Issues the memory access in
// the request cycle and reports shaped data and flags one cycle later.
// Assumes a synchronous memory returning mem_rdata one cycle after mem_en,
// and that no memory access is made for a faulted request.
module lsa_unit
    import lsa_pkg::*;
#(
    parameter int unsigned ADDR_W = LSA_ADDR_W,
    parameter int unsigned DATA_W = LSA_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_kind,
    input  logic                  req_store,
    input  logic                  req_signed,
    input  logic                  req_compact,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  chk_en,
    input  logic                  pair_word_ok,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  resp_valid,
    output logic [DATA_W-1:0]     resp_data,
    output logic                  resp_fault,
    output logic                  resp_unpred
);

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);

    acc_kind_e        kind;
    logic             fault_c;
    logic             unpred_c;
    acc_kind_e        r_kind;
    logic [OFF_W-1:0] r_off;
    logic             r_sgn;
    logic             r_load;
    logic [DATA_W-1:0] ld_data;

    assign kind = acc_kind_e'(req_kind);

    lsa_align_check #(.OFF_W(OFF_W)) u_check (
        .kind         (kind),
        .off          (req_addr[OFF_W:0]),
        .chk_en       (chk_en),
        .compact      (req_compact),
        .pair_word_ok (pair_word_ok),
        .fault        (fault_c),
        .unpred       (unpred_c)
    );

    // memory handshake: a faulted request makes no access
    always_comb begin
        mem_en = req_valid & ~fault_c;
        mem_we = mem_en & req_store;
    end

    lsa_store_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .kind      (kind),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .wr_en     (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata)
    );

    // capture response flags and load context for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_fault  <= 1'b0;
            resp_unpred <= 1'b0;
            r_kind      <= ACC_BYTE;
            r_off       <= '0;
            r_sgn       <= 1'b0;
            r_load      <= 1'b0;
        end else begin
            resp_valid  <= req_valid;
            resp_fault  <= req_valid & fault_c;
            resp_unpred <= req_valid & unpred_c;
            r_kind      <= kind;
            r_off       <= req_addr[OFF_W-1:0];
            r_sgn       <= req_signed;
            r_load      <= req_valid & ~req_store;
        end
    end

    lsa_load_path #(.DATA_W(DATA_W)) u_load (
        .kind  (r_kind),
        .off   (r_off),
        .sgn   (r_sgn),
        .rdata (mem_rdata),
        .ldata (ld_data)
    );

    // returned data is meaningful only for loads that made an access
    always_comb begin
        resp_data = (resp_valid & r_load & ~resp_fault) ? ld_data : '0;
    end

endmodule

// File: rtl/lsa_unit_chk.sv
// Port-level checker for lsa_unit, bound to every instance of it.
// Assumes req_kind carries only the six defined codes.
module lsa_unit_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [2:0]            req_kind,
    input logic                  req_store,
    input logic [ADDR_W-1:0]     req_addr,
    input logic                  chk_en,
    input logic                  mem_en,
    input logic                  mem_we,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [DATA_W/8-1:0]   mem_be,
    input logic                  resp_valid,
    input logic                  resp_fault,
    input logic                  resp_unpred
);

    // R1
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R1
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R12
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_fault && resp_unpred));

    // R12
    flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_fault || resp_unpred) |-> resp_valid);

    // R2
    word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr[1:0] == 2'b00 && mem_addr[ADDR_W-1:2] == req_addr[ADDR_W-1:2]));

    // R8
    fault_needs_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> $past(chk_en));

    // R6
    unpred_needs_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_unpred |-> !$past(chk_en));

    // R10
    byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd0) |=> (!resp_fault && !resp_unpred));

    // R5
    multi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4) |=> (!resp_fault && !resp_unpred));

    // R8
    half_fault_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_en && req_kind == 3'd1 && req_addr[0]) |-> !mem_en);

    // R10
    byte_be_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && req_kind == 3'd0) |-> $countones(mem_be) == 1);

    // R4
    write_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (req_valid && req_store && mem_en));

endmodule

bind lsa_unit lsa_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_store   (req_store),
    .req_addr    (req_addr),
    .chk_en      (chk_en),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .resp_valid  (resp_valid),
    .resp_fault  (resp_fault),
    .resp_unpred (resp_unpred)
);

// File: tb/sim_lsa_unit.sv
`timescale 1ns/1ps
// Scoreboard bench for lsa_unit: the driver predicts each response and
// queues it; the monitor pops and compares on every response cycle.
module sim_lsa_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic        req_store = 1'b0;
    logic        req_signed = 1'b0;
    logic        req_compact = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        chk_en = 1'b0;
    logic        pair_word_ok = 1'b0;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid, resp_fault, resp_unpred;
    logic [31:0] resp_data;

    typedef struct {
        logic        fault;
        logic        unpred;
        logic        chk_data;
        logic [31:0] data;
        string       rq_flag;
        string       rq_data;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] ram [16];
    logic [31:0] shadow [16];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    lsa_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_store(req_store), .req_signed(req_signed), .req_compact(req_compact),
        .req_addr(req_addr), .req_wdata(req_wdata), .chk_en(chk_en),
        .pair_word_ok(pair_word_ok), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_fault(resp_fault), .resp_unpred(resp_unpred)
    );

    // synchronous memory model driven only by the unit's memory outputs
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) ram[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= ram[mem_addr[5:2]];
            end
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] ror8(input logic [31:0] w, input int k);
        logic [31:0] r = w;
        for (int i = 0; i < k; i++) r = {r[7:0], r[31:8]};
        return r;
    endfunction

    // one request: predict, check memory-side outputs, queue the response
    task automatic issue(input int kind, input bit st, input bit sg, input bit cmp,
                         input logic [31:0] a, input logic [31:0] wd);
        bit mis, flt, unp;
        logic [3:0]  be_e;
        logic [31:0] wd_e, w, ld;
        int off, idx;
        exp_t e;
        off = int'(a[1:0]);
        idx = int'(a[5:2]);
        case (kind)
            1: mis = a[0];
            2, 5: mis = (a[1:0] != 2'b00);
            3: mis = pair_word_ok ? (a[1:0] != 2'b00) : (a[2:0] != 3'b000);
            default: mis = 1'b0;
        endcase
        flt = chk_en & mis;
        unp = !chk_en & mis & (((kind != 2) && (kind != 5)) || cmp);
        case (kind)
            0: begin be_e = 4'b0001 << off; wd_e = {4{wd[7:0]}}; end
            1: begin be_e = a[1] ? 4'b1100 : 4'b0011; wd_e = {2{wd[15:0]}}; end
            default: begin be_e = 4'b1111; wd_e = wd; end
        endcase
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(kind); req_store = st; req_signed = sg;
        req_compact = cmp; req_addr = a; req_wdata = wd;
        #1;
        // R8: a faulted request makes no access
        check(mem_en === !flt, "R8 mem_en", {31'd0, mem_en}, {31'd0, !flt});
        check(mem_we === (st & !flt), "R8 mem_we", {31'd0, mem_we}, {31'd0, st & !flt});
        if (!flt) check(mem_addr === {a[31:2], 2'b00}, "R2 mem_addr", mem_addr, {a[31:2], 2'b00});
        if (st && !flt) begin
            string rq = (kind == 0) ? "R10 store" : (kind == 1) ? "R11 store" :
                        (kind == 2 || kind == 5) ? "R4 store" : "R5 store";
            check(mem_be === be_e, rq, {28'd0, mem_be}, {28'd0, be_e});
            check(mem_wdata === wd_e, rq, mem_wdata, wd_e);
            for (int b = 0; b < 4; b++)
                if (be_e[b]) shadow[idx][8*b +: 8] = wd_e[8*b +: 8];
        end
        w = shadow[idx];
        case (kind)
            0: begin ld = ror8(w, off); ld = sg ? {{24{ld[7]}}, ld[7:0]} : {24'd0, ld[7:0]}; end
            1: begin ld = a[1] ? {16'd0, w[31:16]} : {16'd0, w[15:0]};
                     if (sg) ld = {{16{ld[15]}}, ld[15:0]}; end
            2, 5: ld = ror8(w, off);
            default: ld = w;
        endcase
        e.fault = flt; e.unpred = unp;
        e.chk_data = !st && !flt && !unp;
        e.data = ld;
        case (kind)
            0: begin e.rq_flag = "R10 flags"; e.rq_data = "R10 load"; end
            1: begin e.rq_flag = chk_en ? "R8 half flags" : "R6 half flags"; e.rq_data = "R11 load"; end
            2, 5: begin e.rq_flag = chk_en ? "R8 word flags" : (cmp ? "R7 word flags" : "R3 word flags");
                        e.rq_data = "R3 load"; end
            3: begin e.rq_flag = "R9 pair flags"; e.rq_data = "R5 pair load"; end
            default: begin e.rq_flag = "R5 multi flags"; e.rq_data = "R5 multi load"; end
        endcase
        sb_q.push_back(e);
    endtask

    // monitor: pop one prediction per response cycle and compare
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(resp_valid === 1'b1, "R1 resp_valid", {31'd0, resp_valid}, 32'd1);
            check(resp_fault === e.fault, e.rq_flag, {31'd0, resp_fault}, {31'd0, e.fault});
            check(resp_unpred === e.unpred, e.rq_flag, {31'd0, resp_unpred}, {31'd0, e.unpred});
            check(!(resp_fault && resp_unpred), "R12 exclusive", {30'd0, resp_fault, resp_unpred}, 32'd0);
            if (e.chk_data) check(resp_data === e.data, e.rq_data, resp_data, e.data);
        end
    end

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n = 0;
        for (int i = 0; i < 16; i++) begin
            ram[i] = 32'h80FF7F01 + 32'(i) * 32'h9E3779B1;
            shadow[i] = ram[i];
        end
        repeat (3) @(negedge clk);
        // R12: reset state
        check(resp_valid === 1'b0, "R12 reset valid", {31'd0, resp_valid}, 32'd0);
        check(resp_fault === 1'b0, "R12 reset fault", {31'd0, resp_fault}, 32'd0);
        check(resp_unpred === 1'b0, "R12 reset unpred", {31'd0, resp_unpred}, 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++)
            for (int pw = 0; pw < 2; pw++) begin
                @(negedge clk);
                req_valid = 1'b0;
                @(negedge clk);
                @(negedge clk);
                chk_en = c[0]; pair_word_ok = pw[0];
                for (int cm = 0; cm < 2; cm++)
                    for (int k = 0; k < 6; k++)
                        for (int st = 0; st < 2; st++)
                            for (int sg = 0; sg < 2; sg++)
                                for (int off = 0; off < 8; off++) begin
                                    logic [31:0] a;
                                    a = 32'h1000_0000 | 32'((n % 14) * 4 + off);
                                    issue(k, st[0], sg[0], cm[0], a, 32'hC3A5_5A81 ^ (32'(n) * 32'h0101_0107));
                                    n++;
                                end
            end
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        // R1: no response without a request
        check(resp_valid === 1'b0, "R1 idle", {31'd0, resp_valid}, 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule